// File: doc/BRIEF.md
# Serial In-System Programming Command Engine

This block is the serial slave that lets an external programmer load the on-chip flash while the device is held in its programming reset. The programmer drives a slow serial clock and a data line; the engine oversamples both with the system clock, assembles bytes MSB first and groups them into four-byte instructions. Each instruction is decoded and turned into strobes on a plain synchronous flash port (address, write data, write strobe, erase strobe, one-cycle read data), or into a reply byte that is shifted back on the serial output line.

The engine refuses all work until it has seen the enable handshake, which it acknowledges by returning a fixed code during the last byte of the instruction. A three-level protection state is held in the engine: the levels must be set in order, they only grow, and only a chip erase clears them. Besides single-byte read and write, whole 256-byte pages can be streamed in or out after a two-byte header. Protection suppresses writes at the first level and masks read data at the second.

Top module: `isp_prog_engine`

## Requirements
- R1: While `rst_n` is low, `miso`, `mem_we` and `mem_erase` are 0 and all protection levels are cleared (a protection read returns 0x00 afterwards).
- R2: After `prog_en` rises, serial clock edges are ignored until `sck` has stayed low for GUARD_CYCLES (64) consecutive system clocks; a high `sck` during that wait restarts it.
- R3: Each byte is shifted MSB first; `mosi` is taken on the rising serial clock edge and `miso` changes only after a falling edge; bytes are grouped four per instruction.
- R4: Instruction 0xAC 0x53 xx xx enables the engine and returns 0x69 in byte 4. Before enabling, every other instruction has no effect and returns 0x00; dropping `prog_en` cancels the enable.
- R5: Byte read 0x20: byte 4 returns the flash byte at address {byte2[3:0], byte3}.
- R6: Byte write 0x40: one `mem_we` pulse writes byte 4 to address {byte2[3:0], byte3}.
- R7: Chip erase, 0xAC with byte 2 matching 100x_xxxx: one `mem_erase` pulse and all protection levels cleared.
- R8: Protection write, 0xAC with byte 2 = 1110_00 b1 b0: code 01 sets level 1, 10 sets level 2 only if level 1 is set, 11 sets level 3 only if level 2 is set, 00 does nothing; levels are never cleared by this instruction.
- R9: Protection read 0x24: byte 4 returns {5'b0, L3, L2, L1}, a set level reading 1.
- R10: Signature read 0x28: byte 4 returns SIGNATURE[8k+7:8k] where k = byte3[1:0].
- R11: Page write 0x50: byte 2 low nibble selects the page; the next 256 bytes are written to offsets 0 to 255 of it.
- R12: Page read 0x30: after the two header bytes, the next 256 bytes return offsets 0 to 255 of the page; only then is a new instruction decoded.
- R13: With level 1 set, byte and page writes raise no `mem_we`; with level 2 set, byte and page reads return 0xFF.
- R14: An unknown opcode consumes four bytes with no effect; bytes that carry no reply return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the whole engine |
| prog_en | input | 1 | High while the device is held in programming reset |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| mem_addr | output | ADDR_W | Flash address |
| mem_wdata | output | 8 | Flash write data |
| mem_we | output | 1 | One-cycle flash write strobe |
| mem_erase | output | 1 | One-cycle whole-array erase strobe |
| mem_rdata | input | 8 | Flash read data, valid one cycle after address |

## Verification
The decoder is tried with enable, byte read and write, signature, protection, erase, unknown-opcode and page streams, each producing a distinct reply or flash side effect that a queue-based scoreboard compares against a bench-side flash model. Sending instructions before enabling and after leaving programming mode tells a gated engine from one that acts at once, and early clock pulses during the guard wait tell a guarded framer from one that shifts misaligned bits. Setting protection codes out of order separates ordered accumulation from plain setting, and a byte read right after a full page stream shows the 258-byte framing boundary.

// File: rtl/isp_pkg.sv
package isp_pkg;
   localparam logic [7:0] OP_SYS      = 8'hAC;
   localparam logic [7:0] OP_EN_KEY   = 8'h53;
   localparam logic [7:0] OP_RD_BYTE  = 8'h20;
   localparam logic [7:0] OP_WR_BYTE  = 8'h40;
   localparam logic [7:0] OP_RD_LOCK  = 8'h24;
   localparam logic [7:0] OP_RD_SIG   = 8'h28;
   localparam logic [7:0] OP_RD_PAGE  = 8'h30;
   localparam logic [7:0] OP_WR_PAGE  = 8'h50;
   localparam logic [7:0] ECHO_CODE   = 8'h69;

   typedef enum logic [1:0] {
      ST_CMD  = 2'd0,
      ST_PGWR = 2'd1,
      ST_PGRD = 2'd2
   } isp_state_e;
endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
   parameter int SYNC_STAGES  = 2,
   parameter int GUARD_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prog_en,
   input  logic sck,
   input  logic mosi,
   output logic rise,
   output logic fall,
   output logic mosi_s
);
   localparam int CW = $clog2(GUARD_CYCLES + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (GUARD_CYCLES < 1) begin : g_bad_guard
      $error("GUARD_CYCLES must be positive");
   end

   logic [SYNC_STAGES-1:0] sck_ff, mosi_ff;
   logic                   sck_prev;
   logic [CW-1:0]          wait_cnt;
   logic                   armed;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               sck_ff[0]  <= 1'b0;
               mosi_ff[0] <= 1'b0;
            end else begin
               sck_ff[0]  <= sck;
               mosi_ff[0] <= mosi;
            end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               sck_ff[s]  <= 1'b0;
               mosi_ff[s] <= 1'b0;
            end else begin
               sck_ff[s]  <= sck_ff[s-1];
               mosi_ff[s] <= mosi_ff[s-1];
            end
      end
   end

   wire sck_s = sck_ff[SYNC_STAGES-1];
   assign mosi_s = mosi_ff[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sck_prev <= 1'b0;
         wait_cnt <= '0;
         armed    <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         if (!prog_en) begin
            wait_cnt <= '0;
            armed    <= 1'b0;
         end else if (!armed) begin
            if (sck_s)
               wait_cnt <= '0;
            else if (wait_cnt == CW'(GUARD_CYCLES - 1))
               armed <= 1'b1;
            else
               wait_cnt <= wait_cnt + 1'b1;
         end
      end

   assign rise = armed &&  sck_s && !sck_prev;
   assign fall = armed && !sck_s &&  sck_prev;

   AST_EDGE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise || fall) |-> prog_en); // R2
endmodule

// File: rtl/isp_byte_shift.sv
module isp_byte_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       prog_en,
   input  logic       rise,
   input  logic       fall,
   input  logic       mosi_s,
   input  logic [7:0] tx_next,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic       miso
);
   logic [2:0] bit_cnt;
   logic [7:0] sh;
   logic [7:0] tx;
   logic       pend;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         bit_cnt   <= '0;
         sh        <= '0;
         tx        <= '0;
         pend      <= 1'b0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else if (!prog_en) begin
         bit_cnt   <= '0;
         tx        <= '0;
         pend      <= 1'b0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (rise) begin
            sh      <= {sh[6:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) begin
               byte_done <= 1'b1;
               rx_byte   <= {sh[6:0], mosi_s};
               pend      <= 1'b1;
            end
         end
         if (fall) begin
            if (pend) begin
               tx   <= tx_next;
               pend <= 1'b0;
            end else begin
               tx <= {tx[6:0], 1'b0};
            end
         end
      end

   assign miso = tx[7];

   AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
      $past(prog_en) && !$past(fall) |-> $stable(miso)); // R3
endmodule

// File: rtl/isp_decoder.sv
module isp_decoder
   import isp_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter logic [31:0] SIGNATURE = 32'hA53C_960F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic              byte_done,
   input  logic [7:0]        rx_byte,
   input  logic [7:0]        mem_rdata,
   output logic [7:0]        tx_next,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   output logic              mem_erase
);
   localparam int HI_W = ADDR_W - 8;

   if (ADDR_W < 9 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 9..12");
   end

   isp_state_e      state;
   logic [1:0]      bidx;
   logic [7:0]      op, b1;
   logic [1:0]      sig_sel;
   logic [HI_W-1:0] page;
   logic [7:0]      cnt;
   logic            enabled;
   logic [2:0]      lock;

   logic [7:0] sig_b [4];
   for (genvar g = 0; g < 4; g++) begin : g_sig
      assign sig_b[g] = SIGNATURE[8*g +: 8];
   end

   wire is_enable = (op == OP_SYS) && (b1 == OP_EN_KEY);
   wire is_erase  = (op == OP_SYS) && (b1[7:5] == 3'b100);
   wire is_lockwr = (op == OP_SYS) && (b1[7:2] == 6'b111000);
   wire rd_mask   = lock[1];
   wire wr_block  = lock[0];

   always_comb begin
      tx_next = 8'h00;
      if (state == ST_PGRD)
         tx_next = rd_mask ? 8'hFF : mem_rdata;
      else if (state == ST_CMD && bidx == 2'd3) begin
         if (is_enable)
            tx_next = ECHO_CODE;
         else if (enabled) begin
            case (op)
               OP_RD_BYTE: tx_next = rd_mask ? 8'hFF : mem_rdata;
               OP_RD_LOCK: tx_next = {5'b0, lock};
               OP_RD_SIG:  tx_next = sig_b[sig_sel];
               default:    tx_next = 8'h00;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state     <= ST_CMD;
         bidx      <= '0;
         op        <= '0;
         b1        <= '0;
         sig_sel   <= '0;
         page      <= '0;
         cnt       <= '0;
         enabled   <= 1'b0;
         lock      <= '0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         mem_we    <= 1'b0;
         mem_erase <= 1'b0;
      end else if (!prog_en) begin
         state     <= ST_CMD;
         bidx      <= '0;
         enabled   <= 1'b0;
         mem_we    <= 1'b0;
         mem_erase <= 1'b0;
      end else begin
         mem_we    <= 1'b0;
         mem_erase <= 1'b0;
         if (byte_done) begin
            case (state)
               ST_CMD: begin
                  case (bidx)
                     2'd0: begin
                        op   <= rx_byte;
                        bidx <= 2'd1;
                     end
                     2'd1: begin
                        b1 <= rx_byte;
                        if (enabled && (op == OP_RD_PAGE || op == OP_WR_PAGE)) begin
                           page     <= rx_byte[HI_W-1:0];
                           cnt      <= '0;
                           mem_addr <= {rx_byte[HI_W-1:0], 8'h00};
                           state    <= (op == OP_RD_PAGE) ? ST_PGRD : ST_PGWR;
                           bidx     <= 2'd0;
                        end else begin
                           bidx <= 2'd2;
                        end
                     end
                     2'd2: begin
                        sig_sel  <= rx_byte[1:0];
                        mem_addr <= {b1[HI_W-1:0], rx_byte};
                        bidx     <= 2'd3;
                     end
                     default: begin
                        bidx <= 2'd0;
                        if (is_enable)
                           enabled <= 1'b1;
                        else if (enabled) begin
                           if (is_erase) begin
                              mem_erase <= 1'b1;
                              lock      <= '0;
                           end else if (is_lockwr) begin
                              case (b1[1:0])
                                 2'b01:   lock[0] <= 1'b1;
                                 2'b10:   if (lock[0]) lock[1] <= 1'b1;
                                 2'b11:   if (lock[1]) lock[2] <= 1'b1;
                                 default: ;
                              endcase
                           end else if (op == OP_WR_BYTE && !wr_block) begin
                              mem_we    <= 1'b1;
                              mem_wdata <= rx_byte;
                           end
                        end
                     end
                  endcase
               end
               ST_PGWR: begin
                  if (!wr_block) begin
                     mem_we    <= 1'b1;
                     mem_wdata <= rx_byte;
                  end
                  mem_addr <= {page, cnt};
                  cnt      <= cnt + 1'b1;
                  if (cnt == 8'hFF) state <= ST_CMD;
               end
               default: begin
                  mem_addr <= {page, cnt + 8'd1};
                  cnt      <= cnt + 1'b1;
                  if (cnt == 8'hFF) state <= ST_CMD;
               end
            endcase
         end
      end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_erase)); // R6
   AST_WE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (lock == 3'b000)); // R13
   AST_LOCK_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (lock == 3'b000) || (lock == 3'b001) || (lock == 3'b011) || (lock == 3'b111)); // R8
   AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(lock) & ~lock)) |-> mem_erase); // R7
   AST_PAGE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_CMD) |-> enabled); // R11
endmodule

// File: rtl/isp_prog_engine.sv
module isp_prog_engine #(
   parameter int          ADDR_W       = 12,
   parameter int          SYNC_STAGES  = 2,
   parameter int          GUARD_CYCLES = 64,
   parameter logic [31:0] SIGNATURE    = 32'hA53C_960F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic              sck,
   input  logic              mosi,
   output logic              miso,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   output logic              mem_erase,
   input  logic [7:0]        mem_rdata
);
   logic       rise, fall, mosi_s, byte_done;
   logic [7:0] rx_byte, tx_next;

   isp_sck_sync #(.SYNC_STAGES(SYNC_STAGES), .GUARD_CYCLES(GUARD_CYCLES)) u_sync (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck), .mosi(mosi),
      .rise(rise), .fall(fall), .mosi_s(mosi_s));

   isp_byte_shift u_shift (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .rise(rise), .fall(fall),
      .mosi_s(mosi_s), .tx_next(tx_next), .byte_done(byte_done),
      .rx_byte(rx_byte), .miso(miso));

   isp_decoder #(.ADDR_W(ADDR_W), .SIGNATURE(SIGNATURE)) u_dec (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .byte_done(byte_done),
      .rx_byte(rx_byte), .mem_rdata(mem_rdata), .tx_next(tx_next),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_erase(mem_erase));
endmodule

// File: tb/isp_prog_engine_test.sv
`timescale 1ns/1ps
module isp_prog_engine_test;
   localparam int AW = 12;
   localparam int MD = 1 << AW;
   localparam logic [31:0] SIG = 32'hA53C_960F;

   logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b0, sck = 1'b0, mosi = 1'b0;
   logic miso, mem_we, mem_erase;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;

   always #4 clk = ~clk;

   isp_prog_engine #(.ADDR_W(AW), .SIGNATURE(SIG)) uut (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck), .mosi(mosi),
      .miso(miso), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_erase(mem_erase), .mem_rdata(mem_rdata));

   logic [7:0] flash [MD];
   logic [7:0] ref_m [MD];

   initial for (int i = 0; i < MD; i++) begin
      flash[i] = 8'(i) ^ 8'h5A;
      ref_m[i] = 8'(i) ^ 8'h5A;
   end

   always @(posedge clk) begin
      mem_rdata <= flash[mem_addr];
      if (mem_we) flash[mem_addr] <= mem_wdata;
      if (mem_erase) for (int i = 0; i < MD; i++) flash[i] <= 8'hFF;
   end

   int checks = 0, fails = 0;
   bit done = 0;
   logic [7:0] exp_q[$];
   logic [7:0] got_q[$];
   string      tag_q[$];

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   initial forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0)
         check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
   end

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   task automatic xfer(input logic [7:0] b, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk) mosi = b[i];
         repeat (9) @(negedge clk);
         r[i] = miso;
         sck = 1'b1;
         repeat (10) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic cmd(input logic [7:0] a, b, c, d, exp, input string tag);
      logic [7:0] r;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      xfer(a, r); xfer(b, r); xfer(c, r); xfer(d, r);
      got_q.push_back(r);
   endtask

   task automatic enter_mode();
      @(negedge clk) prog_en = 1'b1;
      repeat (80) @(negedge clk);
   endtask

   task automatic rd(input int addr, input logic [7:0] exp, input string tag);
      cmd(8'h20, 8'(addr >> 8), 8'(addr), 8'h00, exp, tag);
   endtask

   task automatic wr(input int addr, input logic [7:0] d, input logic en_ok, input logic lk);
      cmd(8'h40, 8'(addr >> 8), 8'(addr), d, 8'h00, "R6 write reply");
      if (en_ok && !lk) ref_m[addr] = d;
   endtask

   task automatic lockwr(input logic [1:0] code);
      cmd(8'hAC, {6'b111000, code}, 8'h00, 8'h00, 8'h00, "R8 lock write reply");
   endtask

   initial begin
      logic [7:0] r;
      repeat (5) @(negedge clk);
      check("R1 reset miso", {7'b0, miso}, 8'h00);
      check("R1 reset we", {6'b0, mem_erase, mem_we}, 8'h00);
      rst_n = 1'b1;
      // guard wait with early pulses (R2)
      @(negedge clk) prog_en = 1'b1;
      for (int p = 0; p < 3; p++) begin
         repeat (5) @(negedge clk); sck = 1'b1;
         repeat (5) @(negedge clk); sck = 1'b0;
      end
      repeat (80) @(negedge clk);
      wr(5, 8'h11, 1'b0, 1'b0);                                // R4 not enabled
      cmd(8'hAC, 8'h53, 8'h00, 8'h00, 8'h69, "R2 R3 R4 enable echo after guard");
      rd(5, ref_m[5], "R4 write before enable ignored");
      cmd(8'hAC, 8'h53, 8'hFF, 8'hFF, 8'h69, "R4 enable echo repeat");
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h00, "R1 R9 lock clear after reset");
      wr(12'h123, 8'hA7, 1'b1, 1'b0);
      rd(12'h123, 8'hA7, "R5 R6 byte write readback");
      rd(12'hFFF, ref_m[12'hFFF], "R5 top address read");
      rd(12'h000, ref_m[0], "R5 bottom address read");
      for (int k = 0; k < 4; k++)
         cmd(8'h28, 8'h00, 8'(k), 8'h00, SIG[8*k +: 8], "R10 signature byte");
      cmd(8'h77, 8'h12, 8'h34, 8'h56, 8'h00, "R14 unknown opcode reply");
      cmd(8'hAC, 8'h53, 8'h00, 8'h00, 8'h69, "R14 framing after unknown");
      rd(12'h234, ref_m[12'h234], "R14 unknown opcode no effect");
      // page write, page 3 (R11)
      xfer(8'h50, r); xfer(8'h03, r);
      for (int k = 0; k < 256; k++) begin
         xfer(8'(k * 7 + 1), r);
         ref_m[12'h300 + k] = 8'(k * 7 + 1);
      end
      rd(12'h3FF, ref_m[12'h3FF], "R11 page write last offset");
      rd(12'h300, ref_m[12'h300], "R11 page write first offset");
      // page read (R12)
      xfer(8'h30, r); xfer(8'h03, r);
      for (int k = 0; k < 256; k++) begin
         exp_q.push_back(ref_m[12'h300 + k]);
         tag_q.push_back("R12 page read data");
         xfer(8'h00, r);
         got_q.push_back(r);
      end
      cmd(8'hAC, 8'h53, 8'h00, 8'h00, 8'h69, "R12 decode resumes after page");
      // ordered protection (R8)
      lockwr(2'b11);
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h00, "R8 level3 out of order ignored");
      lockwr(2'b10);
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h00, "R8 level2 out of order ignored");
      lockwr(2'b00);
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h00, "R8 code 00 no change");
      lockwr(2'b01);
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h01, "R8 R9 level1 set");
      wr(12'h010, 8'h33, 1'b1, 1'b1);
      rd(12'h010, ref_m[12'h010], "R13 write blocked by level1");
      lockwr(2'b11);
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h01, "R8 level3 before level2 ignored");
      lockwr(2'b10);
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h03, "R8 level2 set");
      rd(12'h123, 8'hFF, "R13 read masked by level2");
      lockwr(2'b11);
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h07, "R8 R9 level3 set");
      lockwr(2'b01);
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h07, "R8 levels never drop");
      // erase (R7)
      cmd(8'hAC, 8'h9F, 8'h00, 8'h00, 8'h00, "R7 erase reply");
      for (int i = 0; i < MD; i++) ref_m[i] = 8'hFF;
      cmd(8'h24, 8'h00, 8'h00, 8'h00, 8'h00, "R7 erase clears levels");
      rd(12'h123, 8'hFF, "R7 erase clears array");
      wr(12'h040, 8'hC3, 1'b1, 1'b0);
      rd(12'h040, 8'hC3, "R7 write allowed after erase");
      // leave and re-enter mode (R4)
      @(negedge clk) prog_en = 1'b0;
      repeat (10) @(negedge clk);
      enter_mode();
      wr(12'h020, 8'h44, 1'b0, 1'b0);
      cmd(8'h28, 8'h00, 8'h01, 8'h00, 8'h00, "R4 no reply before re-enable");
      cmd(8'hAC, 8'h53, 8'h00, 8'h00, 8'h69, "R4 re-enable echo");
      rd(12'h020, 8'hFF, "R4 enable cancelled by mode exit");
      repeat (20) @(negedge clk);
      summary();
   end
endmodule